// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Stack

This block tracks where one warp is executing and which of its lanes take part. It keeps the current program counter and active-lane mask. When a conditional branch splits the active lanes, it sends the warp down the taken path with only the taking lanes enabled. It also records two stack entries: one for the merge point and one for the deferred not-taken path. Each entry stores a merge address, a lane mask and a resume address.

On every update the block forms a candidate next address. This is the sequential address or the branch outcome. If the stack is not empty and the candidate equals the merge address of the top entry, the warp resumes from that entry's address with that entry's mask, and the entry is removed. In this way the deferred path runs once the first path ends, and the full mask returns at the merge point. Lanes whose mask bit is clear still see every instruction but must not commit results; gating that commit is done downstream.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `cur_pc` is RESET_PC (default 0), `cur_mask` has every lane bit set, `overflow` is 0 and the stack is empty.
- R2: `warp_init` loads `cur_pc` from `init_pc` and `cur_mask` from `init_mask`, empties the stack and clears `overflow`, whatever else is asserted in that cycle.
- R3: `adv` with no branch moves `cur_pc` to `cur_pc + INSN_BYTES` (8 by default) and keeps `cur_mask`, unless a pop (R7, R8) applies.
- R4: On a branch, let the effective taken set be `br_taken & cur_mask`. If it is zero, the PC moves to `br_fallthru`. If it equals `cur_mask`, the PC moves to `br_target`. In both cases the mask is kept and nothing is pushed.
- R5: On a divergent branch (effective taken set neither zero nor all of `cur_mask`), two entries are pushed in order. The first is {merge `br_reconv`, mask `cur_mask`, resume `br_reconv`}. The second is {merge `br_reconv`, mask `cur_mask & ~br_taken`, resume `br_fallthru`}. The warp then runs at `br_target` under the effective taken set.
- R6: Bits of `br_taken` for lanes outside `cur_mask` have no effect on the branch outcome or on any mask.
- R7: When the candidate next PC of an `adv` or a non-divergent branch equals the merge address of the top entry, `cur_pc` and `cur_mask` are loaded from that entry's resume address and mask, and one entry is popped.
- R8: If, in that case, the top entry's resume address equals the merge address of the entry below it (an empty path), both entries are popped and the lower entry's resume address and mask are loaded.
- R9: A divergent branch while fewer than two entries are free sets `overflow`. In that case nothing is pushed and PC and mask are unchanged. `overflow` stays set until reset or `warp_init`. Uniform branches never set it.
- R10: `warp_init` has priority over `br_valid`, which has priority over `adv`. With none of them asserted, PC and mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_init | input | 1 | Start the warp at `init_pc` with `init_mask` |
| init_pc | input | PC_W | Start address |
| init_mask | input | LANES | Start lane mask |
| adv | input | 1 | Non-branch instruction issued; advance sequentially |
| br_valid | input | 1 | Branch resolved this cycle |
| br_taken | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PC_W | Taken-path address |
| br_fallthru | input | PC_W | Not-taken-path address |
| br_reconv | input | PC_W | Merge address of the two paths |
| cur_pc | output | PC_W | Address the warp executes next |
| cur_mask | output | LANES | Lanes enabled for that instruction |
| overflow | output | 1 | Sticky: a divergent branch found the stack without room |

## Verification
The hardest states to reach are a nested divergence whose inner merge is reached before the outer deferred path runs, an empty else-path where two entries must retire in one step, and a stack filled to exactly its depth. The stimulus table sets up a two-level nest and walks each inner and outer path to its merge point. A branch whose fall-through address equals its merge address produces the empty path. The directed part then chains eight divergent branches, each clearing one different lane, to fill the sixteen entries. It follows with a uniform branch and one more divergent branch on the full stack.

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES      = 32,
  parameter int DEPTH      = 16,
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warp_init,
  input  logic [PC_W-1:0]  init_pc,
  input  logic [LANES-1:0] init_mask,
  input  logic             adv,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  output logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic             overflow
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);
  localparam logic [SPW-1:0] ROOM_MAX = SPW'(DEPTH - 2);

  logic [PC_W-1:0]  stk_rpc [DEPTH];
  logic [PC_W-1:0]  stk_epc [DEPTH];
  logic [LANES-1:0] stk_msk [DEPTH];
  logic [SPW-1:0]   sp;

  logic [LANES-1:0] go_mask, stay_mask;
  logic             divg, room, hit, dbl;
  logic [IW-1:0]    top_i, below_i, push0_i, push1_i;
  logic [PC_W-1:0]  cand_pc;

  assign go_mask   = br_taken & cur_mask;
  assign stay_mask = cur_mask & ~go_mask;
  assign divg      = br_valid && (go_mask != '0) && (stay_mask != '0);
  assign room      = sp <= ROOM_MAX;

  assign top_i   = IW'(sp - SPW'(1));
  assign below_i = IW'(sp - SPW'(2));
  assign push0_i = IW'(sp);
  assign push1_i = IW'(sp + SPW'(1));

  assign cand_pc = !br_valid         ? cur_pc + STEP :
                   (go_mask == '0)   ? br_fallthru   : br_target;

  assign hit = (sp != '0) && (cand_pc == stk_rpc[top_i]);
  assign dbl = hit && (sp >= SPW'(2)) && (stk_epc[top_i] == stk_rpc[below_i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pc   <= RESET_PC;
      cur_mask <= '1;
      sp       <= '0;
      overflow <= 1'b0;
    end else if (warp_init) begin
      cur_pc   <= init_pc;
      cur_mask <= init_mask;
      sp       <= '0;
      overflow <= 1'b0;
    end else if (divg) begin
      if (room) begin
        sp       <= sp + SPW'(2);
        cur_pc   <= br_target;
        cur_mask <= go_mask;
      end else begin
        overflow <= 1'b1;
      end
    end else if (br_valid || adv) begin
      if (dbl) begin
        cur_pc   <= stk_epc[below_i];
        cur_mask <= stk_msk[below_i];
        sp       <= sp - SPW'(2);
      end else if (hit) begin
        cur_pc   <= stk_epc[top_i];
        cur_mask <= stk_msk[top_i];
        sp       <= sp - SPW'(1);
      end else begin
        cur_pc   <= cand_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !warp_init && divg && room) begin
      stk_rpc[push0_i] <= br_reconv;
      stk_msk[push0_i] <= cur_mask;
      stk_epc[push0_i] <= br_reconv;
      stk_rpc[push1_i] <= br_reconv;
      stk_msk[push1_i] <= stay_mask;
      stk_epc[push1_i] <= br_fallthru;
    end
  end
endmodule

module simt_reconv_stack_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int INSN_BYTES = 8,
  parameter int SPW   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             warp_init,
  input logic             adv,
  input logic             br_valid,
  input logic [LANES-1:0] br_taken,
  input logic [PC_W-1:0]  cur_pc,
  input logic [LANES-1:0] cur_mask,
  input logic             overflow,
  input logic [SPW-1:0]   sp
);
  logic [LANES-1:0] eff;
  logic             split;
  assign eff   = br_taken & cur_mask;
  assign split = (eff != '0) && (eff != cur_mask);

  always_comb a_r5_depth_bound: assert (!rst_n || sp <= SPW'(DEPTH));

  a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !br_valid && !warp_init && sp == '0) |=>
      (cur_pc == $past(cur_pc) + PC_W'(INSN_BYTES)) && (cur_mask == $past(cur_mask)));

  a_r4_uniform_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !warp_init && !split) |=> (sp <= $past(sp)) && !$rose(overflow));

  a_r5_push_two: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !warp_init && split && sp <= SPW'(DEPTH - 2)) |=> sp == $past(sp) + SPW'(2));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !warp_init) |=> overflow);

  a_r9_full_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !warp_init && split && sp > SPW'(DEPTH - 2)) |=>
      overflow && $stable(cur_pc) && $stable(cur_mask) && $stable(sp));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!warp_init && !br_valid && !adv) |=> $stable(cur_pc) && $stable(cur_mask) && $stable(sp));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .SPW(SPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .warp_init(warp_init), .adv(adv), .br_valid(br_valid),
  .br_taken(br_taken), .cur_pc(cur_pc), .cur_mask(cur_mask), .overflow(overflow), .sp(sp)
);

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        warp_init, adv, br_valid;
  logic [31:0] init_pc, init_mask, br_taken, br_target, br_fallthru, br_reconv;
  logic [31:0] cur_pc, cur_mask;
  logic        overflow;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  simt_reconv_stack dut (
    .clk(clk), .rst_n(rst_n), .warp_init(warp_init), .init_pc(init_pc), .init_mask(init_mask),
    .adv(adv), .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .cur_pc(cur_pc), .cur_mask(cur_mask), .overflow(overflow)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic [31:0] tk, tg, ft, rc, epc, emsk;
  } vec_t;

  localparam logic [1:0] ADV = 2'd0, BR = 2'd1, INI = 2'd2;
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  INI, 32'hFFFFFFFF, 32'h100, 32'h0,   32'h0,   32'h100, 32'hFFFFFFFF}, // R2
    '{8'd3,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h108, 32'hFFFFFFFF}, // R3
    '{8'd5,  BR,  32'h0000FFFF, 32'h200, 32'h110, 32'h300, 32'h200, 32'h0000FFFF}, // R5
    '{8'd3,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h208, 32'h0000FFFF}, // R3
    '{8'd4,  BR,  32'hFFFFFFFF, 32'h2F8, 32'h218, 32'h400, 32'h2F8, 32'h0000FFFF}, // R4
    '{8'd7,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h110, 32'hFFFF0000}, // R7
    '{8'd3,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h118, 32'hFFFF0000}, // R3
    '{8'd4,  BR,  32'h0,        32'h500, 32'h2F8, 32'h0,   32'h2F8, 32'hFFFF0000}, // R4
    '{8'd7,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h300, 32'hFFFFFFFF}, // R7
    '{8'd3,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h308, 32'hFFFFFFFF}, // R3
    '{8'd5,  BR,  32'h00FF00FF, 32'h400, 32'h310, 32'h600, 32'h400, 32'h00FF00FF}, // R5
    '{8'd6,  BR,  32'hF000000F, 32'h480, 32'h408, 32'h500, 32'h480, 32'h0000000F}, // R6
    '{8'd4,  BR,  32'hFFFFFFFF, 32'h4F8, 32'h0,   32'h0,   32'h4F8, 32'h0000000F}, // R4
    '{8'd7,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h408, 32'h00FF00F0}, // R7
    '{8'd4,  BR,  32'h0,        32'h0,   32'h4F8, 32'h0,   32'h4F8, 32'h00FF00F0}, // R4
    '{8'd7,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h500, 32'h00FF00FF}, // R7
    '{8'd4,  BR,  32'hFFFFFFFF, 32'h5F8, 32'h0,   32'h0,   32'h5F8, 32'h00FF00FF}, // R4
    '{8'd7,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h310, 32'hFF00FF00}, // R7
    '{8'd4,  BR,  32'h0,        32'h0,   32'h5F8, 32'h0,   32'h5F8, 32'hFF00FF00}, // R4
    '{8'd7,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h600, 32'hFFFFFFFF}, // R7
    '{8'd5,  BR,  32'h00000001, 32'h700, 32'h800, 32'h800, 32'h700, 32'h00000001}, // R5
    '{8'd4,  BR,  32'hFFFFFFFF, 32'h7F8, 32'h0,   32'h0,   32'h7F8, 32'h00000001}, // R4
    '{8'd8,  ADV, 32'h0,        32'h0,   32'h0,   32'h0,   32'h800, 32'hFFFFFFFF}  // R8
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    warp_init = 0; adv = 0; br_valid = 0;
  endtask

  task automatic step(input logic i, input logic a, input logic b, input logic [31:0] tk,
                      input logic [31:0] tg, input logic [31:0] ft, input logic [31:0] rc);
    warp_init = i; adv = a; br_valid = b;
    init_pc = tg; init_mask = tk;
    br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    init_pc = 0; init_mask = 0; br_taken = 0; br_target = 0; br_fallthru = 0; br_reconv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "pc", cur_pc, 32'h0);
    chk("R1", "mask", cur_mask, 32'hFFFFFFFF);
    chk("R1", "overflow", {31'b0, overflow}, 32'h0);
    @(negedge clk);
    chk("R10", "idle pc", cur_pc, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].op == INI, VEC[k].op == ADV, VEC[k].op == BR,
           VEC[k].tk, VEC[k].tg, VEC[k].ft, VEC[k].rc);
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vec%0d pc", k), cur_pc, VEC[k].epc);
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vec%0d mask", k), cur_mask, VEC[k].emsk);
    end
    chk("R8", "overflow after table", {31'b0, overflow}, 32'h0);

    // R9: fill the stack with eight divergent branches
    step(1, 0, 0, 32'hFFFFFFFF, 32'h1000, 0, 0);
    for (int b = 0; b < 8; b++)
      step(0, 0, 1, ~(32'h1 << b), 32'h1000 + 32'((b + 1) * 256), 32'hF000, 32'hE000);
    chk("R9", "full pc", cur_pc, 32'h1800);
    chk("R9", "full mask", cur_mask, 32'hFFFFFF00);
    step(0, 0, 1, 32'hFFFFFFFF, 32'h1900, 32'hF000, 32'hE000);
    chk("R9", "uniform on full pc", cur_pc, 32'h1900);
    chk("R9", "uniform on full no overflow", {31'b0, overflow}, 32'h0);
    step(0, 0, 1, ~(32'h1 << 8), 32'h2000, 32'hF000, 32'hE000);
    chk("R9", "overflow set", {31'b0, overflow}, 32'h1);
    chk("R9", "overflow pc held", cur_pc, 32'h1900);
    chk("R9", "overflow mask held", cur_mask, 32'hFFFFFF00);
    step(0, 1, 0, 0, 0, 0, 0);
    chk("R9", "overflow sticky", {31'b0, overflow}, 32'h1);
    chk("R3", "advance after overflow", cur_pc, 32'h1908);

    // R2 / R10: init wins over branch and advance, and clears overflow
    warp_init = 1; adv = 1; br_valid = 1;
    init_pc = 32'h40; init_mask = 32'h0000F0F0;
    br_taken = 32'hFFFFFFFF; br_target = 32'h900; br_fallthru = 0; br_reconv = 0;
    @(negedge clk);
    idle_inputs();
    chk("R2", "init pc", cur_pc, 32'h40);
    chk("R2", "init mask", cur_mask, 32'h0000F0F0);
    chk("R2", "init clears overflow", {31'b0, overflow}, 32'h0);
    // R10: branch wins over advance
    step(0, 1, 1, 32'hFFFFFFFF, 32'h900, 32'h48, 32'h0);
    chk("R10", "branch over adv", cur_pc, 32'h900);
    chk("R6", "mask after uniform", cur_mask, 32'h0000F0F0);
    @(negedge clk);
    chk("R10", "hold", cur_pc, 32'h900);
    // R1: reset again mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1", "reset pc", cur_pc, 32'h0);
    chk("R1", "reset mask", cur_mask, 32'hFFFFFFFF);

    summary();
    $finish;
  end
endmodule